// File: doc/BRIEF.md
# Secondary Core Power-Up Sequencer

This block is a small hardware state machine that walks one secondary processor core out of reset and power-gated isolation and into the running state. A one-cycle start request begins the walk. The block then updates two register images in a fixed order: a per-core power-control word and a power-gate control word. The steps of the walk are holding the core in reset with its clamps applied, enabling the head switch, lifting the memory clamp, putting the L2 data array to sleep, removing the isolation clamp, releasing both resets and, last, flagging the core as powered up.

Each step keeps every bit that earlier steps left set, so the power-control image builds up over the walk. Three settle waits separate groups of steps. Each wait is two microseconds long, counted in system clocks from a clocks-per-microsecond parameter. The first wait also holds until the head switch has seen its programmed number of reference-oscillator ticks. A busy flag covers the whole walk, and a one-cycle done pulse marks its end.

Top module: `core_wake_seq`

## Requirements
- R1: During and after a synchronous active-high reset, both register images are zero and busy and done are low.
- R2: A start request sampled at an edge while idle loads the power-control image with 0x0000_0033 at that same edge. This sets bit 5 (power-on reset), bit 4 (core reset), bit 1 (memory clamp) and bit 0 (clamp). Busy rises at that edge.
- R3: One clock later, the power-gate image becomes 0x1000_0001. This is the head-switch enable at bit 0 plus a head-switch count of 16 in the field starting at bit 24.
- R4: Let the gate write happen at edge G, and let T be the edge of the 16th reference tick sampled after G. The memory clamp is cleared at edge max(G + 2*CLKS_PER_US, T) + 1.
- R5: The memory-clamp clear gives 0x0000_0031. The next edge sets L2 sleep (bit 3), giving 0x0000_0039.
- R6: Exactly 2*CLKS_PER_US + 1 clocks after the L2 sleep write, bit 17 is set and clamp is cleared in one write, giving 0x0002_0038.
- R7: Exactly 2*CLKS_PER_US + 1 clocks after that, both resets are cleared, giving 0x0002_0008. On the next edge the powered-up bit (bit 7) is set, giving 0x0002_0088.
- R8: Done is high for exactly one cycle, at the edge of the powered-up write. Busy is high from the start edge through the edge before done, and falls with done.
- R9: A start request while busy has no effect: the register values and their timing are unchanged, and done pulses only once. While idle, neither register image changes.
- R10: A start after done replays the whole walk from the reset-hold write, with the same values and spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin the power-up walk |
| ref_tick_i | input | 1 | One-cycle pulse per reference-oscillator period |
| pwr_ctl_o | output | REG_W | Per-core power-control register image |
| gate_ctl_o | output | REG_W | Power-gate control register image |
| busy_o | output | 1 | High while the walk is in progress |
| done_o | output | 1 | One-cycle pulse when the core is flagged powered up |

## Verification
The assertions assume that start_i and ref_tick_i are synchronous to clk and free of X. They also assume the parameters give a settle wait of at least one clock and a head-switch count of at least one. The bench drives both inputs only on falling edges from seeded random draws, so they are always clean single-clock levels. The reference tick density is varied between runs, so that in some runs the timer ends the first wait and in others the head-switch tick count ends it. Extra start pulses are scattered while busy to exercise R9.

// File: rtl/cws_pkg.sv
package cws_pkg;

  localparam int BIT_CLAMP    = 0;
  localparam int BIT_MEMCLAMP = 1;
  localparam int BIT_L2SLEEP  = 3;
  localparam int BIT_CORERST  = 4;
  localparam int BIT_PORRST   = 5;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_GATE,
    SQ_WAIT_HS,
    SQ_MEMCLR,
    SQ_L2SLP,
    SQ_WAIT_L2,
    SQ_UNCLAMP,
    SQ_WAIT_ISO,
    SQ_UNRST,
    SQ_PWRUP
  } seq_state_t;

endpackage

// File: rtl/cws_settle_timer.sv
module cws_settle_timer #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOADV = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOADV;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

  // R6: the count never exceeds the loaded settle length
  a_r6_timer_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOADV);

  // R7: a running, unexpired timer counts down by one each clock
  a_r7_timer_step: assert property (@(posedge clk) disable iff (rst)
    run_i && !load_i && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/cws_ref_tick_count.sv
module cws_ref_tick_count #(
  parameter int TARGET = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic en_i,
  input  logic tick_i,
  output logic reached_o
);
  localparam int CW = $clog2(TARGET + 1);
  localparam logic [CW-1:0] TOP = CW'(TARGET);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (en_i && tick_i && (cnt_q != TOP)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // the tick on the current edge already counts toward the target
  assign reached_o = (cnt_q == TOP) || (tick_i && (cnt_q == TOP - 1'b1));

  // R4: the tick count saturates at the programmed head-switch count
  a_r4_tick_saturate: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP);

  // R4: without a tick the count holds
  a_r4_tick_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_i && !clear_i |=> $stable(cnt_q));

endmodule

// File: rtl/core_wake_seq.sv
module core_wake_seq #(
  parameter int REG_W        = 32,
  parameter int CLKS_PER_US  = 50,
  parameter int SETTLE_US    = 2,
  parameter int HS_EN_BIT    = 0,
  parameter int HS_CNT_SHIFT = 24,
  parameter int HS_CNT       = 16,
  parameter int ISO_BIT      = 17,
  parameter int PWRUP_BIT    = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             ref_tick_i,
  output logic [REG_W-1:0] pwr_ctl_o,
  output logic [REG_W-1:0] gate_ctl_o,
  output logic             busy_o,
  output logic             done_o
);
  import cws_pkg::*;

  localparam int WAIT_CYC = CLKS_PER_US * SETTLE_US;
  localparam logic [REG_W-1:0] ONE = REG_W'(1);
  localparam logic [REG_W-1:0] HOLD_VAL =
    (ONE << BIT_PORRST) | (ONE << BIT_CORERST) |
    (ONE << BIT_MEMCLAMP) | (ONE << BIT_CLAMP);
  localparam logic [REG_W-1:0] GATE_VAL =
    (ONE << HS_EN_BIT) | (REG_W'(HS_CNT) << HS_CNT_SHIFT);

  seq_state_t state_q;
  logic [REG_W-1:0] pwr_q, gate_q;
  logic busy_q, done_q;
  logic tmr_load, tmr_run, tmr_exp;
  logic hs_clear, hs_en, hs_reached;

  assign tmr_load = (state_q == SQ_GATE) || (state_q == SQ_L2SLP) ||
                    (state_q == SQ_UNCLAMP);
  assign tmr_run  = (state_q == SQ_WAIT_HS) || (state_q == SQ_WAIT_L2) ||
                    (state_q == SQ_WAIT_ISO);
  assign hs_clear = (state_q == SQ_GATE);
  assign hs_en    = (state_q == SQ_WAIT_HS);

  cws_settle_timer #(.CYCLES(WAIT_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .run_i     (tmr_run),
    .expired_o (tmr_exp)
  );

  cws_ref_tick_count #(.TARGET(HS_CNT)) u_hs_ticks (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (hs_clear),
    .en_i      (hs_en),
    .tick_i    (ref_tick_i),
    .reached_o (hs_reached)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      pwr_q   <= '0;
      gate_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            pwr_q   <= HOLD_VAL;
            busy_q  <= 1'b1;
            state_q <= SQ_GATE;
          end
        end
        SQ_GATE: begin
          gate_q  <= GATE_VAL;
          state_q <= SQ_WAIT_HS;
        end
        SQ_WAIT_HS: begin
          if (tmr_exp && hs_reached) state_q <= SQ_MEMCLR;
        end
        SQ_MEMCLR: begin
          pwr_q[BIT_MEMCLAMP] <= 1'b0;
          state_q <= SQ_L2SLP;
        end
        SQ_L2SLP: begin
          pwr_q[BIT_L2SLEEP] <= 1'b1;
          state_q <= SQ_WAIT_L2;
        end
        SQ_WAIT_L2: begin
          if (tmr_exp) state_q <= SQ_UNCLAMP;
        end
        SQ_UNCLAMP: begin
          pwr_q[ISO_BIT]   <= 1'b1;
          pwr_q[BIT_CLAMP] <= 1'b0;
          state_q <= SQ_WAIT_ISO;
        end
        SQ_WAIT_ISO: begin
          if (tmr_exp) state_q <= SQ_UNRST;
        end
        SQ_UNRST: begin
          pwr_q[BIT_CORERST] <= 1'b0;
          pwr_q[BIT_PORRST]  <= 1'b0;
          state_q <= SQ_PWRUP;
        end
        SQ_PWRUP: begin
          pwr_q[PWRUP_BIT] <= 1'b1;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign pwr_ctl_o  = pwr_q;
  assign gate_ctl_o = gate_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  // R1: reset clears both images and the flags
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pwr_q == '0) && (gate_q == '0) && !busy_q && !done_q);

  // R8: done is a single-cycle pulse and never coincides with busy
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

  // R9: while idle without a start, neither image changes
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !busy_q && !start_i |=> $stable(pwr_q) && $stable(gate_q));

  // R9: a busy walk never drops out early, whatever start does
  a_r9_stay_busy: assert property (@(posedge clk) disable iff (rst)
    busy_q && (state_q != SQ_PWRUP) |=> busy_q);

  // R4: memory clamp lifts only with the head switch enabled
  a_r4_switch_first: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_q[BIT_MEMCLAMP]) |-> gate_q[HS_EN_BIT]);

  // R7: resets are released only after isolation has been removed
  a_r7_unclamp_first: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_q[BIT_CORERST]) |-> !pwr_q[BIT_CLAMP] && pwr_q[ISO_BIT]);

  // R6: the power-control image is frozen during every settle wait
  a_r6_wait_frozen: assert property (@(posedge clk) disable iff (rst)
    tmr_run |=> $stable(pwr_q));

endmodule

// File: tb/test_core_wake_seq.sv
module test_core_wake_seq;
  localparam int CPU = 50;
  localparam int W   = 2 * CPU;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic ref_tick_i = 1'b0;
  logic [31:0] pwr_ctl_o, gate_ctl_o;
  logic busy_o, done_o;

  always #10 clk = ~clk;

  core_wake_seq #(.CLKS_PER_US(CPU)) i_core_wake_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .ref_tick_i(ref_tick_i),
    .pwr_ctl_o(pwr_ctl_o), .gate_ctl_o(gate_ctl_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  int tick_pct = 50;
  int tick_edge [0:1023];
  int ntick = 0;
  logic [31:0] chg_val [0:15];
  int chg_edge [0:15];
  int nchg = 0;
  logic [31:0] last_pwr = '0;
  bit finished = 0;

  function automatic logic [31:0] exp_pwr(input int k);
    logic [31:0] v;
    v = (32'd1 << 5) | (32'd1 << 4) | (32'd1 << 1) | (32'd1 << 0);
    if (k >= 1) v[1] = 1'b0;
    if (k >= 2) v[3] = 1'b1;
    if (k >= 3) begin v[17] = 1'b1; v[0] = 1'b0; end
    if (k >= 4) begin v[4] = 1'b0; v[5] = 1'b0; end
    if (k >= 5) v[7] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] exp_gate();
    return (32'd1 << 0) | (32'd16 << 24);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    ecount = ecount + 1;
    if (ref_tick_i && ntick < 1024) begin
      tick_edge[ntick] = ecount;
      ntick = ntick + 1;
    end
  end

  always @(negedge clk) begin
    if (pwr_ctl_o != last_pwr) begin
      if (nchg < 16) begin
        chg_val[nchg]  = pwr_ctl_o;
        chg_edge[nchg] = ecount;
      end
      nchg = nchg + 1;
      last_pwr = pwr_ctl_o;
    end
    ref_tick_i <= (int'($urandom % 100) < tick_pct);
  end

  task automatic run_seq(input int pct, input bit spurious, input string tag);
    int s, g, m, t16, seen, done_edge, done_cnt, busy_bad;
    tick_pct = pct;
    @(negedge clk);
    nchg = 0;
    ntick = 0;
    start_i = 1'b1;
    s = ecount + 1;
    g = s + 1;
    done_cnt = 0;
    done_edge = 0;
    busy_bad = 0;
    @(negedge clk);
    start_i = 1'b0;
    while (done_cnt == 0 && !finished) begin
      if (busy_o !== 1'b1) busy_bad++;
      start_i = spurious && ($urandom % 6 == 0);
      @(negedge clk);
      if (done_o) begin done_cnt++; done_edge = ecount; end
    end
    start_i = 1'b0;
    chk({tag, " R8 busy falls with done"}, {31'd0, busy_o}, 32'd0);
    chk({tag, " R8 busy held through walk"}, busy_bad, 0);
    @(negedge clk);
    if (done_o) done_cnt++;
    chk({tag, " R8 done one cycle"}, done_cnt, 1);
    t16 = 0; seen = 0;
    for (int i = 0; i < ntick; i++) begin
      if (tick_edge[i] > g && seen < 16) begin
        seen++;
        if (seen == 16) t16 = tick_edge[i];
      end
    end
    m = ((g + W) > t16 ? (g + W) : t16) + 1;
    chk({tag, " R5 change count"}, nchg, 6);
    chk({tag, " R2 hold value"}, chg_val[0], exp_pwr(0));
    chk({tag, " R2 hold edge"}, chg_edge[0], s);
    chk({tag, " R3 gate value"}, gate_ctl_o, exp_gate());
    chk({tag, " R4 memclamp edge"}, chg_edge[1], m);
    chk({tag, " R5 memclamp value"}, chg_val[1], exp_pwr(1));
    chk({tag, " R5 l2 sleep value"}, chg_val[2], exp_pwr(2));
    chk({tag, " R5 l2 sleep edge"}, chg_edge[2], m + 1);
    chk({tag, " R6 unclamp value"}, chg_val[3], exp_pwr(3));
    chk({tag, " R6 unclamp edge"}, chg_edge[3], m + 2 + W);
    chk({tag, " R7 unreset value"}, chg_val[4], exp_pwr(4));
    chk({tag, " R7 unreset edge"}, chg_edge[4], m + 3 + 2 * W);
    chk({tag, " R7 powered up value"}, chg_val[5], exp_pwr(5));
    chk({tag, " R7 powered up edge"}, chg_edge[5], m + 4 + 2 * W);
    chk({tag, " R8 done edge"}, done_edge, m + 4 + 2 * W);
    repeat (20) @(negedge clk);
    chk({tag, " R9 idle pwr hold"}, pwr_ctl_o, exp_pwr(5));
    chk({tag, " R9 idle gate hold"}, gate_ctl_o, exp_gate());
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset pwr", pwr_ctl_o, 32'd0);
    chk("R1 reset gate", gate_ctl_o, 32'd0);
    chk("R1 reset busy", {31'd0, busy_o}, 32'd0);
    chk("R1 reset done", {31'd0, done_o}, 32'd0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 idle no start", pwr_ctl_o, 32'd0);
    // directed: every-cycle ticks, timer ends the first wait
    run_seq(100, 1'b0, "dense");
    // directed: sparse ticks, tick count ends the first wait
    run_seq(4, 1'b0, "sparse");
    // R10 replay and R9 spurious starts while busy
    run_seq(50, 1'b1, "r10_replay");
    for (int r = 0; r < 6; r++) begin
      run_seq(3 + int'($urandom % 60), 1'(r % 2), "random");
    end
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 mid reset pwr", pwr_ctl_o, 32'd0);
    chk("R1 mid reset gate", gate_ctl_o, 32'd0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule